// File: doc/BRIEF.md
# Ethernet receive-path wake-up controller

This block sits beside the receive path of an Ethernet MAC and owns the low-power listening state used for remote wake. Software puts the block into power-down with a control write. While power-down is active, no received frame reaches the application: the block masks the forwarded valid, start and end strobes for every frame that begins in that state.

Two external detectors report candidate wake events as single-cycle hit pulses during a frame. One detector looks for a magic packet and the other looks for a programmed wake-up pattern. A hit counts only if its source is enabled, the block is in power-down, and the frame carrying it ends with a good CRC. When a hit counts, the block leaves power-down on its own, sets a sticky flag naming the source and raises an interrupt. The block does not gate any clock. The frame that caused the wake is still dropped, and forwarding starts again at the start of the next frame. A status read clears the flags and the interrupt.

Top module: `rxwake_ctrl`

## Requirements
- R1: After reset, pd_active, wake_magic, wake_wfrm and wake_irq are all 0.
- R2: When csr_wr is high, the block loads csr_wdata. Bit 1 is the magic-packet enable and bit 2 is the wake-pattern enable. Bit 0 = 1 sets pd_active from the next cycle. Bit 0 = 0 leaves pd_active unchanged.
- R3: A frame whose start beat (rx_valid and rx_sof) arrives while pd_active is 0 is forwarded whole. On each of its beats, fwd_valid equals rx_valid, and fwd_sof and fwd_eof copy rx_sof and rx_eof. This holds even if power-down is set in the middle of the frame.
- R4: A frame whose start beat arrives while pd_active is 1 produces no fwd_valid, fwd_sof or fwd_eof on any of its beats.
- R5: Suppose the magic-packet enable is set and a magic_hit arrives on a beat of a power-down frame whose end beat has rx_crc_ok = 1. In the cycle after that end beat, pd_active is 0, wake_magic is 1 and wake_irq is 1.
- R6: The same holds for wfrm_hit with the wake-pattern enable set: wake_wfrm is 1, pd_active is 0 and wake_irq is 1 in the cycle after the end beat.
- R7: A hit whose source enable is clear has no effect on pd_active or on the flags.
- R8: A hit in a frame whose end beat has rx_crc_ok = 0 has no effect on pd_active or on the flags.
- R9: The frame that triggers a wake is dropped completely. The next frame is forwarded from its start beat.
- R10: A csr_rd pulse clears wake_magic, wake_wfrm and wake_irq in the next cycle. If a wake event arrives in the same cycle as the read, the wake event takes priority.
- R11: A hit while pd_active is 0 has no effect on the flags.
- R12: A hit counts on any beat from the start beat to the end beat of its frame. A hit from an earlier frame never carries into a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Control write strobe |
| csr_wdata | input | 3 | Control write data: bit0 power-down set, bit1 magic enable, bit2 wake-pattern enable |
| csr_rd | input | 1 | Status read strobe; clears the flags |
| rx_valid | input | 1 | Receive beat valid |
| rx_sof | input | 1 | Receive beat is the frame start |
| rx_eof | input | 1 | Receive beat is the frame end |
| rx_crc_ok | input | 1 | Frame CRC is good; qualified by the end beat |
| magic_hit | input | 1 | Magic-packet detector hit pulse |
| wfrm_hit | input | 1 | Wake-pattern matcher hit pulse |
| fwd_valid | output | 1 | Beat forwarded to the application |
| fwd_sof | output | 1 | Forwarded frame start |
| fwd_eof | output | 1 | Forwarded frame end |
| pd_active | output | 1 | Power-down state |
| wake_magic | output | 1 | Sticky flag: wake caused by a magic packet |
| wake_wfrm | output | 1 | Sticky flag: wake caused by a wake pattern |
| wake_irq | output | 1 | Wake interrupt |

## Verification
The forward strobes are combinational in the current beat, so they are due in the same cycle as the receive beat. The bench drives each beat just after a rising edge and compares the forward strobes at the following falling edge against a queue filled by the driver. pd_active, the two flags and the interrupt are registered: they change on the edge that captures the end beat, the control write or the status read. The bench therefore samples them just after that single edge. It checks both that a change took place and that no change took place where the requirements forbid one.

// File: rtl/wkc_pkg.sv
// Shared definitions for the receive wake-up controller.
// Assumes two wake sources; source indices are fixed below.
package wkc_pkg;
    localparam int NUM_SRC   = 2;
    localparam int SRC_MAGIC = 0;
    localparam int SRC_WFRM  = 1;
    localparam int CSR_W     = 3;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Control write layout: bit2 wake-pattern enable, bit1 magic enable, bit0 power-down set
    typedef struct packed {
        logic wfrm_en;
        logic magic_en;
        logic pd_set;
    } ctrl_wr_t;
endpackage

// File: rtl/wkc_hit_qual.sv
// Qualifies detector hits per frame. A hit on any beat of a frame is held
// until the end beat. At the end beat it becomes a wake event if the frame
// CRC is good, the block is in power-down and the source is enabled.
// Assumes frames are well formed (start beat before end beat).
module wkc_hit_qual
    import wkc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx_valid,
    input  logic     rx_sof,
    input  logic     rx_eof,
    input  logic     rx_crc_ok,
    input  src_vec_t hit,
    input  src_vec_t src_en,
    input  logic     pd,
    output src_vec_t wake_ev
);
    logic frame_end_good;
    assign frame_end_good = rx_valid & rx_eof & rx_crc_ok & pd;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic pend_q;
        logic seen;

        // Holds a hit seen earlier in the current frame; restarts at each frame start
        always_ff @(posedge clk) begin
            if (!rst_n)                  pend_q <= 1'b0;
            else if (rx_valid && rx_sof) pend_q <= hit[i] & ~rx_eof;
            else if (rx_valid && rx_eof) pend_q <= 1'b0;
            else if (rx_valid && hit[i]) pend_q <= 1'b1;
        end

        // A stale pending bit is ignored on a start beat
        assign seen       = (pend_q & ~rx_sof) | (rx_valid & hit[i]);
        assign wake_ev[i] = frame_end_good & src_en[i] & seen;
    end

    // A wake event needs an end beat with good CRC (R8)
    assert_wake_needs_good_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_ev) |-> (rx_valid && rx_eof && rx_crc_ok));
endmodule

// File: rtl/wkc_csr.sv
// Control and status state: source enables, power-down bit and sticky wake flags.
// A wake event clears power-down and sets the flag of its source. A status read
// clears the flags unless a wake event arrives in the same cycle.
module wkc_csr
    import wkc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     csr_wr,
    input  ctrl_wr_t csr_wdata,
    input  logic     csr_rd,
    input  src_vec_t wake_ev,
    output logic     pd,
    output src_vec_t src_en,
    output src_vec_t flags,
    output logic     irq
);
    logic pd_q;
    src_vec_t en_q;
    src_vec_t flag_q;

    // Source enables are loaded on every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (csr_wr) begin
            en_q[SRC_MAGIC] <= csr_wdata.magic_en;
            en_q[SRC_WFRM]  <= csr_wdata.wfrm_en;
        end
    end

    // Power-down is set by software and cleared only by a wake event
    always_ff @(posedge clk) begin
        if (!rst_n)                         pd_q <= 1'b0;
        else if (|wake_ev)                  pd_q <= 1'b0;
        else if (csr_wr && csr_wdata.pd_set) pd_q <= 1'b1;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        // Sticky flag per source; a wake event wins over a read clear
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (wake_ev[i]) flag_q[i] <= 1'b1;
            else if (csr_rd)     flag_q[i] <= 1'b0;
        end
    end

    assign pd     = pd_q;
    assign src_en = en_q;
    assign flags  = flag_q;
    assign irq    = |flag_q;

    // A wake event always leaves power-down (R5)
    assert_wake_exits_pd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_ev) |=> !pd_q);
    // Power-down is left only after a wake event (R7)
    assert_pd_exit_only_on_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_q) |-> $past(|wake_ev));
    // A read without a wake event empties the flags (R10)
    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && !(|wake_ev)) |=> (flag_q == '0));
    // The flags hold when there is no read and no wake event (R11)
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_rd && !(|wake_ev)) |=> $stable(flag_q));
endmodule

// File: rtl/wkc_fwd_gate.sv
// Per-frame forward gate. The pass or drop decision is taken on the start beat
// from the power-down state and held for the rest of the frame, so no frame is
// ever forwarded in part.
module wkc_fwd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_sof,
    input  logic rx_eof,
    input  logic pd,
    output logic fwd_valid,
    output logic fwd_sof,
    output logic fwd_eof
);
    logic pass_q;
    logic pass_now;

    // Latches the pass decision at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n)                  pass_q <= 1'b0;
        else if (rx_valid && rx_sof) pass_q <= ~pd;
    end

    assign pass_now  = rx_sof ? ~pd : pass_q;
    assign fwd_valid = rx_valid & pass_now;
    assign fwd_sof   = fwd_valid & rx_sof;
    assign fwd_eof   = fwd_valid & rx_eof;

    // A frame starting in power-down is not forwarded (R4)
    assert_drop_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && pd) |-> !fwd_valid);
    // A forwarded middle beat belongs to a frame whose start was forwarded (R3)
    assert_no_partial_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && !rx_eof && pd) |=> (!(rx_valid && !rx_sof) || !fwd_valid));
endmodule

// File: rtl/rxwake_ctrl.sv
// Top of the receive wake-up controller. It joins the hit qualifier, the
// control and status state and the forward gate. Assumes single-cycle hit
// pulses aligned to receive beats and at least one cycle between an end beat
// and the next start beat.
module rxwake_ctrl
    import wkc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic             csr_rd,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_crc_ok,
    input  logic             magic_hit,
    input  logic             wfrm_hit,
    output logic             fwd_valid,
    output logic             fwd_sof,
    output logic             fwd_eof,
    output logic             pd_active,
    output logic             wake_magic,
    output logic             wake_wfrm,
    output logic             wake_irq
);
    src_vec_t hit_vec;
    src_vec_t en_vec;
    src_vec_t wake_ev;
    src_vec_t flag_vec;
    logic     pd;
    ctrl_wr_t wr_fields;

    assign hit_vec[SRC_MAGIC] = magic_hit;
    assign hit_vec[SRC_WFRM]  = wfrm_hit;
    assign wr_fields          = ctrl_wr_t'(csr_wdata);

    wkc_hit_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_eof    (rx_eof),
        .rx_crc_ok (rx_crc_ok),
        .hit       (hit_vec),
        .src_en    (en_vec),
        .pd        (pd),
        .wake_ev   (wake_ev)
    );

    wkc_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_wdata (wr_fields),
        .csr_rd    (csr_rd),
        .wake_ev   (wake_ev),
        .pd        (pd),
        .src_en    (en_vec),
        .flags     (flag_vec),
        .irq       (wake_irq)
    );

    wkc_fwd_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_eof    (rx_eof),
        .pd        (pd),
        .fwd_valid (fwd_valid),
        .fwd_sof   (fwd_sof),
        .fwd_eof   (fwd_eof)
    );

    assign pd_active  = pd;
    assign wake_magic = flag_vec[SRC_MAGIC];
    assign wake_wfrm  = flag_vec[SRC_WFRM];

    // The interrupt follows the flags: no interrupt with both flags clear (R6)
    assert_irq_matches_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq == (wake_magic || wake_wfrm));
endmodule

// File: tb/rxwake_ctrl_test.sv
// Scoreboard bench: the driver queues the expected forward result of every
// beat, and a monitor pops and compares at each falling edge.
module rxwake_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csr_wr = 1'b0;
    logic [2:0] csr_wdata = '0;
    logic csr_rd = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
    logic magic_hit = 1'b0, wfrm_hit = 1'b0;
    logic fwd_valid, fwd_sof, fwd_eof, pd_active, wake_magic, wake_wfrm, wake_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cur_mp = 1'b0;
    bit cur_wf = 1'b0;
    bit exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxwake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rd(csr_rd), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_crc_ok(rx_crc_ok), .magic_hit(magic_hit), .wfrm_hit(wfrm_hit),
        .fwd_valid(fwd_valid), .fwd_sof(fwd_sof), .fwd_eof(fwd_eof),
        .pd_active(pd_active), .wake_magic(wake_magic), .wake_wfrm(wake_wfrm),
        .wake_irq(wake_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compares the forward strobes of each beat with the queued expectation
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " fwd_valid"}, int'(fwd_valid), int'(e));
                check({t, " fwd_sof"}, int'(fwd_sof), int'(e && rx_sof));
                check({t, " fwd_eof"}, int'(fwd_eof), int'(e && rx_eof));
            end
        end
    end

    task automatic csr_write(input bit pd, input bit mp, input bit wf);
        tick();
        csr_wr = 1'b1;
        csr_wdata = {wf, mp, pd};
        cur_mp = mp;
        cur_wf = wf;
        tick();
        csr_wr = 1'b0;
        csr_wdata = '0;
    endtask

    task automatic status_read();
        tick();
        csr_rd = 1'b1;
        tick();
        csr_rd = 1'b0;
    endtask

    // Drives one frame; index -1 disables an option
    task automatic send_frame(input int len, input int mp_at, input int wf_at,
                              input bit crc, input bit exp_fwd, input int pd_at,
                              input int rd_at, input string tag);
        for (int i = 0; i < len; i++) begin
            tick();
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == len - 1);
            rx_crc_ok = crc && (i == len - 1);
            magic_hit = (i == mp_at);
            wfrm_hit = (i == wf_at);
            csr_wr = (i == pd_at);
            csr_wdata = (i == pd_at) ? {cur_wf, cur_mp, 1'b1} : 3'b000;
            csr_rd = (i == rd_at);
            exp_q.push_back(exp_fwd);
            tag_q.push_back(tag);
        end
        tick();
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
        magic_hit = 1'b0; wfrm_hit = 1'b0; csr_wr = 1'b0; csr_wdata = '0; csr_rd = 1'b0;
    endtask

    task automatic check_state(input string tag, input bit pd, input bit m,
                               input bit w, input bit irq);
        check({tag, " pd_active"}, int'(pd_active), int'(pd));
        check({tag, " wake_magic"}, int'(wake_magic), int'(m));
        check({tag, " wake_wfrm"}, int'(wake_wfrm), int'(w));
        check({tag, " wake_irq"}, int'(wake_irq), int'(irq));
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        check_state("R1 reset", 0, 0, 0, 0);

        send_frame(4, -1, -1, 1, 1, -1, -1, "R3 normal frame");
        csr_write(1, 1, 0);
        check("R2 power-down set", int'(pd_active), 1);
        csr_write(0, 1, 0);
        check("R2 bit0 clear keeps power-down", int'(pd_active), 1);

        send_frame(5, -1, -1, 1, 0, -1, -1, "R4 dropped frame");
        check_state("R4 no wake", 1, 0, 0, 0);

        send_frame(4, -1, 1, 1, 0, -1, -1, "R7 disabled source");
        check_state("R7 disabled hit ignored", 1, 0, 0, 0);

        send_frame(4, 2, -1, 0, 0, -1, -1, "R8 bad crc");
        check_state("R8 bad crc ignored", 1, 0, 0, 0);

        send_frame(5, 1, -1, 1, 0, -1, -1, "R9 wake frame dropped");
        check_state("R5 magic wake R12 mid-frame hit", 0, 1, 0, 1);

        send_frame(3, -1, -1, 1, 1, -1, -1, "R9 next frame forwarded");

        status_read();
        check_state("R10 read clears", 0, 0, 0, 0);

        send_frame(4, 0, -1, 1, 1, -1, -1, "R11 hit outside power-down");
        check_state("R11 no flag", 0, 0, 0, 0);

        csr_write(1, 0, 1);
        send_frame(4, -1, 2, 0, 0, -1, -1, "R12 hit in bad frame");
        send_frame(3, -1, -1, 1, 0, -1, -1, "R12 clean frame");
        check_state("R12 no carry-over", 1, 0, 0, 0);

        send_frame(4, -1, 3, 1, 0, -1, 3, "R6 wake with read");
        check_state("R6 wake pattern R10 wake beats read", 0, 0, 1, 1);

        status_read();
        check_state("R10 second read", 0, 0, 0, 0);

        send_frame(5, -1, -1, 1, 1, 2, -1, "R3 pd set mid-frame");
        check("R2 mid-frame set", int'(pd_active), 1);
        send_frame(3, -1, -1, 1, 0, -1, -1, "R4 after mid-frame set");

        csr_write(1, 1, 1);
        send_frame(3, 0, 0, 1, 0, -1, -1, "R5 both sources");
        check_state("R5 R6 both flags", 0, 1, 1, 1);

        repeat (3) tick();
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule